// File: doc/BRIEF.md
# Prefetch Slot Filler with Per-Processor Candidate Registers

This block is one stage inside a memory-side prefetcher. It takes one message per cycle from an input queue and pushes it into an output queue that leads to memory. Demand reads and writes cross the stage untouched. A third kind of message, a prefetch slot, is an empty placeholder that the upstream arbiter sends when the scheduled requester has nothing to do. The stage fills that placeholder with a pending prefetch, or drops it when there is nothing worth fetching.

Pending prefetches arrive on a write port from an address calculator. Each processor owns exactly one candidate register, and a new candidate replaces an old one that was never serviced. Slots are filled by scanning the candidate registers in round-robin order. The scan skips any processor that already has a prefetch in flight. A per-processor in-flight flag is set when a prefetch is issued and cleared by a completion input from the memory side. Both kinds of traffic take the same single cycle to cross, and both wait when the output queue is full.

Top module: `pfslot_merge`

## Requirements
- R1: An accepted message appears on the output registers exactly one clock later. Kind codes: 2'b00 read, 2'b01 write, 2'b10 slot, 2'b11 prefetch. Any message whose kind is not 2'b10 is emitted with its kind, address and processor ID unchanged.
- R2: `in_ready` equals the inverse of `oq_full`. While the output queue is full, no message is taken, whether demand or slot, and no output is produced from that cycle.
- R3: Each processor has one candidate register. A write replaces any pending, unissued value, and only the most recent value is ever issued.
- R4: A slot is served by the first eligible processor, searching upward from a round-robin pointer and wrapping at the top. After a processor is served, the pointer moves to the processor just above it.
- R5: A processor with an in-flight prefetch is never chosen, so at most one prefetch per processor is ever in flight.
- R6: A slot that is served leaves as kind 2'b11, carrying the chosen register's address and the chosen processor's ID. A slot with no eligible candidate is discarded, and `out_valid` stays low for it.
- R7: Issuing a prefetch sets that processor's in-flight flag and empties its candidate register.
- R8: A completion (`rsp_done` with `rsp_pid`) clears that processor's in-flight flag. The processor becomes eligible for slots accepted from the next cycle onward.
- R9: When a candidate write targets the same register that is being issued in the same cycle, the written value remains pending afterwards.
- R10: Reset clears `out_valid`, empties every candidate register, clears every in-flight flag and sets the round-robin pointer to processor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input queue has a message |
| in_kind | input | 2 | Message kind code |
| in_addr | input | ADDR_W | Message address |
| in_pid | input | PID_W | Message processor ID |
| in_ready | output | 1 | Message is taken this cycle if valid |
| oq_full | input | 1 | Output queue cannot accept a push |
| out_valid | output | 1 | Push into the output queue |
| out_kind | output | 2 | Kind of the emitted message |
| out_addr | output | ADDR_W | Address of the emitted message |
| out_pid | output | PID_W | Processor ID of the emitted message |
| cand_we | input | 1 | Write a prefetch candidate |
| cand_pid | input | PID_W | Processor whose register is written |
| cand_addr | input | ADDR_W | Candidate prefetch address |
| rsp_done | input | 1 | A prefetch response has completed |
| rsp_pid | input | PID_W | Processor whose prefetch completed |

## Verification
Two functions can act on the same processor's candidate register in one cycle: a slot issuing from it and the calculator writing a fresh candidate into it. The bench provokes this by loading a register, then writing a second address to it in the same cycle that a slot selects it. The check passes when the first address leaves as the prefetch and a later slot, after the completion clears the in-flight flag, issues the second address. A completion that arrives in the same cycle as a slot is also exercised; that slot must still treat the processor as busy.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic [1:0] {
    MSG_RD   = 2'b00,
    MSG_WR   = 2'b01,
    MSG_SLOT = 2'b10,
    MSG_PF   = 2'b11
  } msg_kind_e;

  function automatic logic kind_is_slot(input logic [1:0] kind);
    return kind == MSG_SLOT;
  endfunction

  // Next round-robin position after idx, wrapping at n.
  function automatic int rr_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Position off steps above base, wrapping at n.
  function automatic int rr_offset(input int base, input int off, input int n);
    int s;
    s = base + off;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/pfm_cand_bank.sv
module pfm_cand_bank #(
  parameter int N_PROC = 4,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              iss_en,
  input  logic [PID_W-1:0]  iss_pid,
  input  logic              rsp_en,
  input  logic [PID_W-1:0]  rsp_pid,
  output logic [N_PROC-1:0] pend,
  output logic [N_PROC-1:0] outst,
  output logic [ADDR_W-1:0] slot_addr [N_PROC]
);

  for (genvar i = 0; i < N_PROC; i++) begin : g_proc
    logic hit_wr, hit_iss, hit_rsp;
    assign hit_wr  = wr_en  && (wr_pid  == PID_W'(i));
    assign hit_iss = iss_en && (iss_pid == PID_W'(i));
    assign hit_rsp = rsp_en && (rsp_pid == PID_W'(i));

    // Candidate register: write wins over issue-clear.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i]      <= 1'b0;
        slot_addr[i] <= '0;
      end else if (hit_wr) begin
        pend[i]      <= 1'b1;
        slot_addr[i] <= wr_addr;
      end else if (hit_iss) begin
        pend[i]      <= 1'b0;
      end
    end

    // In-flight flag: issue sets, completion clears.
    always_ff @(posedge clk) begin
      if (!rst_n)        outst[i] <= 1'b0;
      else if (hit_iss)  outst[i] <= 1'b1;
      else if (hit_rsp)  outst[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pfm_rr_pick.sv
module pfm_rr_pick #(
  parameter int N_PROC = 4,
  parameter int PID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PROC-1:0] elig,
  input  logic              adv_en,
  output logic              found,
  output logic [PID_W-1:0]  pick_pid
);
  import pfm_pkg::*;

  logic [PID_W-1:0] ptr;

  always_comb begin
    found    = 1'b0;
    pick_pid = '0;
    for (int off = 0; off < N_PROC; off++) begin
      int idx;
      idx = rr_offset(int'(ptr), off, N_PROC);
      if (!found && elig[idx]) begin
        found    = 1'b1;
        pick_pid = PID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (adv_en) ptr <= PID_W'(rr_after(int'(pick_pid), N_PROC));
  end

endmodule

// File: rtl/pfm_out_stage.sv
module pfm_out_stage #(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        nxt_kind,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [PID_W-1:0]  nxt_pid,
  output logic              q_valid,
  output logic [1:0]        q_kind,
  output logic [ADDR_W-1:0] q_addr,
  output logic [PID_W-1:0]  q_pid
);

  always_ff @(posedge clk) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= load;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_kind <= '0;
      q_addr <= '0;
      q_pid  <= '0;
    end else if (load) begin
      q_kind <= nxt_kind;
      q_addr <= nxt_addr;
      q_pid  <= nxt_pid;
    end
  end

endmodule

// File: rtl/pfslot_merge.sv
module pfslot_merge #(
  parameter int N_PROC = 4,
  parameter int ADDR_W = 32,
  localparam int PID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PID_W-1:0]  in_pid,
  output logic              in_ready,
  input  logic              oq_full,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [PID_W-1:0]  out_pid,
  input  logic              cand_we,
  input  logic [PID_W-1:0]  cand_pid,
  input  logic [ADDR_W-1:0] cand_addr,
  input  logic              rsp_done,
  input  logic [PID_W-1:0]  rsp_pid
);
  import pfm_pkg::*;

  // Named internal events, also observed by the checker.
  logic              accept;
  logic              is_slot;
  logic              found;
  logic              slot_fire;
  logic              emit;
  logic [PID_W-1:0]  pick_pid;
  logic [N_PROC-1:0] pend;
  logic [N_PROC-1:0] outst;
  logic [N_PROC-1:0] elig;
  logic [ADDR_W-1:0] slot_addr [N_PROC];

  logic [1:0]        nxt_kind;
  logic [ADDR_W-1:0] nxt_addr;
  logic [PID_W-1:0]  nxt_pid;

  assign in_ready  = !oq_full;
  assign accept    = in_valid && in_ready;
  assign is_slot   = kind_is_slot(in_kind);
  assign elig      = pend & ~outst;
  assign slot_fire = accept && is_slot && found;
  assign emit      = accept && (!is_slot || found);

  always_comb begin
    if (is_slot) begin
      nxt_kind = MSG_PF;
      nxt_addr = slot_addr[pick_pid];
      nxt_pid  = pick_pid;
    end else begin
      nxt_kind = in_kind;
      nxt_addr = in_addr;
      nxt_pid  = in_pid;
    end
  end

  pfm_cand_bank #(.N_PROC(N_PROC), .ADDR_W(ADDR_W), .PID_W(PID_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cand_we),
    .wr_pid    (cand_pid),
    .wr_addr   (cand_addr),
    .iss_en    (slot_fire),
    .iss_pid   (pick_pid),
    .rsp_en    (rsp_done),
    .rsp_pid   (rsp_pid),
    .pend      (pend),
    .outst     (outst),
    .slot_addr (slot_addr)
  );

  pfm_rr_pick #(.N_PROC(N_PROC), .PID_W(PID_W)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .adv_en   (slot_fire),
    .found    (found),
    .pick_pid (pick_pid)
  );

  pfm_out_stage #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit),
    .nxt_kind (nxt_kind),
    .nxt_addr (nxt_addr),
    .nxt_pid  (nxt_pid),
    .q_valid  (out_valid),
    .q_kind   (out_kind),
    .q_addr   (out_addr),
    .q_pid    (out_pid)
  );

endmodule

// File: rtl/pfslot_merge_chk.sv
module pfslot_merge_chk #(
  parameter int N_PROC = 4,
  parameter int ADDR_W = 32,
  parameter int PID_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [1:0]        in_kind,
  input logic [ADDR_W-1:0] in_addr,
  input logic [PID_W-1:0]  in_pid,
  input logic              oq_full,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic [PID_W-1:0]  out_pid,
  input logic              cand_we,
  input logic [PID_W-1:0]  cand_pid,
  input logic              accept,
  input logic              found,
  input logic              slot_fire,
  input logic [PID_W-1:0]  pick_pid,
  input logic [N_PROC-1:0] pend,
  input logic [N_PROC-1:0] outst
);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept));

  assert_demand_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind != 2'b10) |=> (out_valid && out_kind == $past(in_kind)
      && out_addr == $past(in_addr) && out_pid == $past(in_pid)));

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oq_full |-> !in_ready);

  assert_skip_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |-> (!outst[pick_pid] && pend[pick_pid]));

  assert_slot_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |=> (out_valid && out_kind == 2'b11 && out_pid == $past(pick_pid)));

  assert_slot_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == 2'b10 && !found) |=> !out_valid);

  assert_issue_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |=> outst[$past(pick_pid)]);

  assert_write_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fire && cand_we && cand_pid == pick_pid) |=> pend[$past(pick_pid)]);

endmodule

bind pfslot_merge pfslot_merge_chk #(.N_PROC(N_PROC), .ADDR_W(ADDR_W), .PID_W(PID_W)) chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .in_kind   (in_kind),
  .in_addr   (in_addr),
  .in_pid    (in_pid),
  .oq_full   (oq_full),
  .out_valid (out_valid),
  .out_kind  (out_kind),
  .out_addr  (out_addr),
  .out_pid   (out_pid),
  .cand_we   (cand_we),
  .cand_pid  (cand_pid),
  .accept    (accept),
  .found     (found),
  .slot_fire (slot_fire),
  .pick_pid  (pick_pid),
  .pend      (pend),
  .outst     (outst)
);

// File: tb/pfslot_merge_test.sv
module pfslot_merge_test;

  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_SL = 2'b10, K_PF = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_kind = '0;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_pid = '0;
  logic        in_ready;
  logic        oq_full = 1'b0;
  logic        out_valid;
  logic [1:0]  out_kind;
  logic [31:0] out_addr;
  logic [1:0]  out_pid;
  logic        cand_we = 1'b0;
  logic [1:0]  cand_pid = '0;
  logic [31:0] cand_addr = '0;
  logic        rsp_done = 1'b0;
  logic [1:0]  rsp_pid = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  pfslot_merge uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr), .in_pid(in_pid),
    .in_ready(in_ready), .oq_full(oq_full),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr), .out_pid(out_pid),
    .cand_we(cand_we), .cand_pid(cand_pid), .cand_addr(cand_addr),
    .rsp_done(rsp_done), .rsp_pid(rsp_pid)
  );

  typedef struct packed {
    logic        cw;  logic [1:0] cp; logic [31:0] ca;
    logic        rs;  logic [1:0] rp;
    logic        iv;  logic [1:0] ik; logic [31:0] ia; logic [1:0] ip;
    logic        full;
    logic        ev;  logic [1:0] ek; logic [31:0] ea; logic [1:0] ep;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    // empty registers: slot dropped (R6)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd6},
    // read passes (R1)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_RD,32'h100,2'd2, 1'b0, 1'b1,K_RD,32'h100,2'd2, 8'd1},
    // write passes, candidate p1 loaded (R1)
    '{1'b1,2'd1,32'hA10, 1'b0,2'd0, 1'b1,K_WR,32'h200,2'd0, 1'b0, 1'b1,K_WR,32'h200,2'd0, 8'd1},
    // slot served by p1 (R6)
    '{1'b1,2'd3,32'hA30, 1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hA10,2'd1, 8'd6},
    // p1 busy, pointer at 2: p3 served (R4 R5)
    '{1'b1,2'd1,32'hB10, 1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hA30,2'd3, 8'd4},
    // only candidate is busy: dropped (R5)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd5},
    // completion same cycle: still busy (R8)
    '{1'b0,2'd0,32'h0,   1'b1,2'd1, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd8},
    // now p1 eligible (R8)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hB10,2'd1, 8'd8},
    // load p2, idle (R3)
    '{1'b1,2'd2,32'hC20, 1'b0,2'd0, 1'b0,K_RD,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd3},
    // overwrite p2, slot blocked by full queue (R2 R3)
    '{1'b1,2'd2,32'hC22, 1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b1, 1'b0,K_RD,32'h0,2'd0,   8'd2},
    // newest p2 value issued (R3)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hC22,2'd2, 8'd3},
    // p0 written this cycle not yet visible: drop (R4)
    '{1'b1,2'd0,32'hD00, 1'b1,2'd3, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd4},
    // pointer at 3 wraps to p0 (R4)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hD00,2'd0, 8'd4},
    // p0 completes (R8)
    '{1'b0,2'd0,32'h0,   1'b1,2'd0, 1'b0,K_RD,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd8},
    // load p0 (R9 setup)
    '{1'b1,2'd0,32'hD02, 1'b0,2'd0, 1'b0,K_RD,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd9},
    // write and issue p0 same cycle (R9)
    '{1'b1,2'd0,32'hD03, 1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hD02,2'd0, 8'd9},
    // p0 completes (R8)
    '{1'b0,2'd0,32'h0,   1'b1,2'd0, 1'b0,K_RD,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd8},
    // kept write now issued (R9)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b1,K_PF,32'hD03,2'd0, 8'd9},
    // register emptied by issue: drop (R7)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_SL,32'h0,2'd0,   1'b0, 1'b0,K_RD,32'h0,2'd0,   8'd7},
    // kind 11 on input passes unchanged (R1)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_PF,32'h300,2'd3, 1'b0, 1'b1,K_PF,32'h300,2'd3, 8'd1},
    // demand read blocked by full queue (R2)
    '{1'b0,2'd0,32'h0,   1'b0,2'd0, 1'b1,K_RD,32'h400,2'd1, 1'b1, 1'b0,K_RD,32'h0,2'd0,   8'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cand_we = v.cw; cand_pid = v.cp; cand_addr = v.ca;
    rsp_done = v.rs; rsp_pid = v.rp;
    in_valid = v.iv; in_kind = v.ik; in_addr = v.ia; in_pid = v.ip;
    oq_full = v.full;
  endtask

  task automatic idle();
    cand_we = 0; rsp_done = 0; in_valid = 0; oq_full = 0;
  endtask

  task automatic step_slot_expect(input string tag, input logic ev,
                                  input logic [31:0] ea, input logic [1:0] ep);
    in_valid = 1; in_kind = K_SL;
    @(posedge clk); @(negedge clk);
    idle();
    chk({tag, " valid"}, 32'(out_valid), 32'(ev));
    if (ev) begin
      chk({tag, " addr"}, out_addr, ea);
      chk({tag, " pid"},  32'(out_pid), 32'(ep));
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid in reset", 32'(out_valid), 32'd0);
    chk("R2 in_ready empty queue", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VECS[i].req, i);
      drive(VECS[i]);
      #1;
      chk({tag, " in_ready"}, 32'(in_ready), 32'(!VECS[i].full));
      @(posedge clk); @(negedge clk);
      chk({tag, " valid"}, 32'(out_valid), 32'(VECS[i].ev));
      if (VECS[i].ev) begin
        chk({tag, " kind"}, 32'(out_kind), 32'(VECS[i].ek));
        chk({tag, " addr"}, out_addr, VECS[i].ea);
        chk({tag, " pid"},  32'(out_pid), 32'(VECS[i].ep));
      end
    end
    idle();

    // R10: reset empties candidate registers
    cand_we = 1; cand_pid = 2; cand_addr = 32'hF00;
    @(posedge clk); @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 out_valid after second reset", 32'(out_valid), 32'd0);
    step_slot_expect("R10 registers emptied", 1'b0, 32'h0, 2'd0);

    // R10: in-flight flags cleared (p0 was busy) and pointer back to 0
    cand_we = 1; cand_pid = 3; cand_addr = 32'hE30;
    @(posedge clk); @(negedge clk);
    cand_pid = 1; cand_addr = 32'hE10;
    @(posedge clk); @(negedge clk);
    cand_pid = 0; cand_addr = 32'hE00;
    @(posedge clk); @(negedge clk);
    idle();
    step_slot_expect("R10 pointer reset picks p0", 1'b1, 32'hE00, 2'd0);
    // R4: then p1, then p3 in round-robin order
    step_slot_expect("R4 next is p1", 1'b1, 32'hE10, 2'd1);
    step_slot_expect("R4 next is p3", 1'b1, 32'hE30, 2'd3);
    // R5: all served processors busy, nothing left
    step_slot_expect("R5 all busy drop", 1'b0, 32'h0, 2'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule